// File: doc/BRIEF.md
# TDM Highway Frame Aligner

This block places a 32-slot serial TDM highway running at 2.048 Mbit/s relative to its frame sync. The transmit and receive directions each have their own programmable offset. The block runs on a fast system clock `clk`. It watches the highway clock `hw_ck`, which is synchronous to `clk`, and treats every transition of `hw_ck` as one clock edge.

A frame sync seen high on a falling `hw_ck` transition marks edge 0. Every later transition advances an edge index, and the index wraps at the frame length. The index is compared against each direction's offset to find the edge where bit 0 of timeslot 0 starts.

Each direction's offset is built from four fields: a byte step, a bit step, a half step and a quarter step. The weight of each field depends on the clock mode, which is either a highway clock equal to the data rate or twice the data rate.

The transmit side works bit by bit. It presents a byte per timeslot, least significant bit first, and drives a tristate enable for each slot from a slot mask. The receive side samples the incoming line in the middle of each bit. It delivers each completed timeslot byte with a one-cycle strobe and the timeslot index.

Top module: `tdmoa_top`

## Requirements
- R1: After reset, `aligned`, `tx_oe`, `rx_valid` and `tx_data` are low.
- R2: A sync is taken only when `hw_fs` is high at a falling transition of `hw_ck` (1 to 0). A high `hw_fs` at a rising transition has no effect. Until the first sync, `aligned` and `tx_oe` stay low and `rx_valid` never pulses.
- R3: Edge indexing and the 1x offset.
  - The sync transition has edge index 0, and each later `hw_ck` transition adds 1.
  - With `mode_2x`=0, the offset is byte*16 + bit*2 + half edges.
  - Bit b of slot s starts at edge (offset + 2*(8s+b)) mod 512.
- R4: With `mode_2x`=1, the offset is byte*32 + bit*4 + half*2 + quarter edges. Bit b of slot s starts at edge (offset + 4*(8s+b)) mod 1024.
- R5: Only the byte offset value modulo 32 matters. With `mode_2x`=0 the quarter input has no effect.
- R6: At the starting edge of each transmit bit, `tx_data` takes bit b of the slot byte, with bit 0 first. `tx_byte` is captured at the start of bit 0 of every slot, and `tx_ts` shows the slot of the bit being sent.
- R7: At the starting edge of each transmit bit, `tx_oe` takes `tx_slot_en[slot]`. Bit i of the mask enables slot i.
- R8: Receive sampling and byte delivery.
  - `rx_data` is sampled at the edge halfway into each receive bit: 1 edge after the bit start in 1x mode, 2 edges after it in 2x mode.
  - Bits are assembled with bit 0 as the LSB. After the bit 7 sample, `rx_valid` pulses for one `clk` cycle together with `rx_byte` and `rx_ts`.
  - Only bytes whose 8 bits were all sampled after the latest sync are delivered.
- R9: Without a further sync, the edge index wraps after 512 edges (1x) or 1024 edges (2x), and the frame repeats with the same alignment.
- R10: A later sync restarts the edge index at 0 at that transition, realigning both directions, and `aligned` stays high.

All outputs change on the `clk` edge that follows the `clk` cycle in which a new `hw_ck` level is first present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the highway clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_2x | input | 1 | 0: highway clock equals data rate; 1: twice data rate |
| hw_ck | input | 1 | Highway clock level, synchronous to `clk` |
| hw_fs | input | 1 | Frame sync, taken on falling `hw_ck` transitions |
| tx_byte_off | input | 7 | Transmit byte offset |
| tx_bit_off | input | 3 | Transmit bit offset |
| tx_half | input | 1 | Transmit half step |
| tx_quar | input | 1 | Transmit quarter step (2x mode only) |
| rx_byte_off | input | 7 | Receive byte offset |
| rx_bit_off | input | 3 | Receive bit offset |
| rx_half | input | 1 | Receive half step |
| rx_quar | input | 1 | Receive quarter step (2x mode only) |
| tx_byte | input | 8 | Byte to send in the slot now starting |
| tx_slot_en | input | 32 | Per-slot drive enable mask |
| tx_data | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Tristate enable for `tx_data` |
| tx_ts | output | 5 | Slot of the bit on `tx_data` |
| rx_data | input | 1 | Serial receive bit |
| rx_byte | output | 8 | Completed receive byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_ts | output | 5 | Slot index of `rx_byte` |
| aligned | output | 1 | A sync has been taken since reset |

## Verification
The bench attacks the fine-step weights in both modes, including the largest offsets that land on the last edge of a frame. A design that weighted half or quarter steps the same way in both modes would shift every bit by one edge, and `tx_data` would then flip at the wrong edge.

It drives sync on a rising transition, which a wrong-edge design would accept as alignment. It also sets byte offsets above 31 and the quarter bit in 1x mode, where a design that used those fields would misplace the frame.

Runs longer than a frame and a mid-frame resync expose a counter that wraps at the wrong length or ignores a second sync. A missing first-byte guard would show as an `rx_valid` pulse carrying a partly sampled byte.

// File: rtl/tdmoa_pkg.sv
package tdmoa_pkg;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = 3;
  typedef enum logic {CK_1X = 1'b0, CK_2X = 1'b1} ck_mode_e;
endpackage

// File: rtl/tdmoa_edge_ctr.sv
module tdmoa_edge_ctr
  import tdmoa_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ck_mode_e         mode,
  input  logic             hw_ck,
  input  logic             hw_fs,
  output logic             step,
  output logic             sync_evt,
  output logic [CNT_W-1:0] e_now,
  output logic             aligned
);
  logic             ck_q;
  logic             edge_evt;
  logic             fall_evt;
  logic             aligned_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] last;

  // Edge detection and next edge index
  always_comb begin
    edge_evt  = hw_ck ^ ck_q;
    fall_evt  = ck_q & ~hw_ck;
    sync_evt  = fall_evt & hw_fs;
    last      = (mode == CK_2X) ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
    if (sync_evt)
      e_now = '0;
    else if (cnt >= last)
      e_now = '0;
    else
      e_now = cnt + 1'b1;
    step      = edge_evt & (aligned | sync_evt);
    cnt_n     = step ? e_now : cnt;
    aligned_n = aligned | sync_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= 1'b0;
      cnt     <= '0;
      aligned <= 1'b0;
    end else begin
      ck_q    <= hw_ck;
      cnt     <= cnt_n;
      aligned <= aligned_n;
    end
  end
endmodule

// File: rtl/tdmoa_phase.sv
module tdmoa_phase
  import tdmoa_pkg::*;
#(
  parameter int NSLOT      = 32,
  parameter int BYTE_OFF_W = 7,
  parameter bit SAMPLE_MID = 1'b0,
  localparam int TS_W      = $clog2(NSLOT),
  localparam int CNT_W     = TS_W + BIT_W + 2
) (
  input  ck_mode_e              mode,
  input  logic [CNT_W-1:0]      e_now,
  input  logic [BYTE_OFF_W-1:0] byte_off,
  input  logic [BIT_W-1:0]      bit_off,
  input  logic                  half,
  input  logic                  quar,
  output logic [TS_W-1:0]       slot,
  output logic [BIT_W-1:0]      bitn,
  output logic                  hit
);
  logic [TS_W-1:0]       byte_lo;
  logic [CNT_W-1:0]      off;
  logic [CNT_W-1:0]      pos;
  logic [TS_W+BIT_W-1:0] bidx;
  logic                  at_start;
  logic                  at_mid;

  always_comb begin
    byte_lo = TS_W'(byte_off % BYTE_OFF_W'(NSLOT));
    if (mode == CK_2X) begin
      off      = {byte_lo, bit_off, half, quar};
      pos      = e_now - off;
      bidx     = pos[CNT_W-1:2];
      at_start = (pos[1:0] == 2'b00);
      at_mid   = (pos[1:0] == 2'b10);
    end else begin
      off      = {1'b0, byte_lo, bit_off, half};
      pos      = e_now - off;
      bidx     = pos[CNT_W-2:1];
      at_start = ~pos[0];
      at_mid   = pos[0];
    end
    slot = bidx[TS_W+BIT_W-1:BIT_W];
    bitn = bidx[BIT_W-1:0];
  end

  // Direction picks its event: bit start for transmit, mid-bit for receive
  generate
    if (SAMPLE_MID) begin : g_mid
      assign hit = at_mid;
    end else begin : g_start
      assign hit = at_start;
    end
  endgenerate
endmodule

// File: rtl/tdmoa_tx.sv
module tdmoa_tx
  import tdmoa_pkg::*;
#(
  parameter int NSLOT  = 32,
  localparam int TS_W  = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 hit,
  input  logic [TS_W-1:0]      slot,
  input  logic [BIT_W-1:0]     bitn,
  input  logic [SLOT_BITS-1:0] tx_byte,
  input  logic [NSLOT-1:0]     slot_en,
  output logic                 tx_data,
  output logic                 tx_oe,
  output logic [TS_W-1:0]      tx_ts
);
  logic [SLOT_BITS-1:0] hold, hold_n;
  logic                 data_n, oe_n;
  logic [TS_W-1:0]      ts_n;

  always_comb begin
    hold_n = hold;
    data_n = tx_data;
    oe_n   = tx_oe;
    ts_n   = tx_ts;
    if (step && hit) begin
      ts_n = slot;
      oe_n = slot_en[slot];
      if (bitn == '0) begin
        hold_n = tx_byte;
        data_n = tx_byte[0];
      end else begin
        data_n = hold[bitn];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      tx_data <= 1'b0;
      tx_oe   <= 1'b0;
      tx_ts   <= '0;
    end else begin
      hold    <= hold_n;
      tx_data <= data_n;
      tx_oe   <= oe_n;
      tx_ts   <= ts_n;
    end
  end
endmodule

// File: rtl/tdmoa_rx.sv
module tdmoa_rx
  import tdmoa_pkg::*;
#(
  parameter int NSLOT  = 32,
  localparam int TS_W  = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 sync_evt,
  input  logic                 hit,
  input  logic [TS_W-1:0]      slot,
  input  logic [BIT_W-1:0]     bitn,
  input  logic                 rx_data,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic [TS_W-1:0]      rx_ts
);
  logic [SLOT_BITS-1:0] sh, sh_n, byte_n;
  logic                 primed, primed_n, primed_c, valid_n;
  logic [TS_W-1:0]      ts_n;

  always_comb begin
    sh_n     = sh;
    byte_n   = rx_byte;
    ts_n     = rx_ts;
    valid_n  = 1'b0;
    primed_c = (step && sync_evt) ? 1'b0 : primed;
    primed_n = primed_c;
    if (step && hit) begin
      sh_n[bitn] = rx_data;
      if (bitn == '0)
        primed_n = 1'b1;
      if (bitn == BIT_W'(SLOT_BITS-1) && primed_c) begin
        valid_n = 1'b1;
        byte_n  = sh_n;
        ts_n    = slot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_ts    <= '0;
      primed   <= 1'b0;
    end else begin
      sh       <= sh_n;
      rx_byte  <= byte_n;
      rx_valid <= valid_n;
      rx_ts    <= ts_n;
      primed   <= primed_n;
    end
  end
endmodule

// File: rtl/tdmoa_top.sv
module tdmoa_top
  import tdmoa_pkg::*;
#(
  parameter int NSLOT      = 32,
  parameter int BYTE_OFF_W = 7,
  localparam int TS_W      = $clog2(NSLOT),
  localparam int CNT_W     = TS_W + BIT_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_2x,
  input  logic                  hw_ck,
  input  logic                  hw_fs,
  input  logic [BYTE_OFF_W-1:0] tx_byte_off,
  input  logic [BIT_W-1:0]      tx_bit_off,
  input  logic                  tx_half,
  input  logic                  tx_quar,
  input  logic [BYTE_OFF_W-1:0] rx_byte_off,
  input  logic [BIT_W-1:0]      rx_bit_off,
  input  logic                  rx_half,
  input  logic                  rx_quar,
  input  logic [SLOT_BITS-1:0]  tx_byte,
  input  logic [NSLOT-1:0]      tx_slot_en,
  output logic                  tx_data,
  output logic                  tx_oe,
  output logic [TS_W-1:0]       tx_ts,
  input  logic                  rx_data,
  output logic [SLOT_BITS-1:0]  rx_byte,
  output logic                  rx_valid,
  output logic [TS_W-1:0]       rx_ts,
  output logic                  aligned
);
  // Reset: asserted asynchronously, released on clk
  logic [1:0] rst_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  ck_mode_e         mode;
  logic             step, sync_evt;
  logic [CNT_W-1:0] e_now;
  assign mode = ck_mode_e'(mode_2x);

  tdmoa_edge_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_s), .mode(mode), .hw_ck(hw_ck), .hw_fs(hw_fs),
    .step(step), .sync_evt(sync_evt), .e_now(e_now), .aligned(aligned)
  );

  // Direction 0 = transmit, 1 = receive
  logic [1:0][BYTE_OFF_W-1:0] boff;
  logic [1:0][BIT_W-1:0]      btoff;
  logic [1:0]                 hf, qf, hit;
  logic [1:0][TS_W-1:0]       slot;
  logic [1:0][BIT_W-1:0]      bitn;
  assign boff  = {rx_byte_off, tx_byte_off};
  assign btoff = {rx_bit_off, tx_bit_off};
  assign hf    = {rx_half, tx_half};
  assign qf    = {rx_quar, tx_quar};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    tdmoa_phase #(
      .NSLOT(NSLOT), .BYTE_OFF_W(BYTE_OFF_W), .SAMPLE_MID(d == 1)
    ) u_ph (
      .mode(mode), .e_now(e_now), .byte_off(boff[d]), .bit_off(btoff[d]),
      .half(hf[d]), .quar(qf[d]), .slot(slot[d]), .bitn(bitn[d]), .hit(hit[d])
    );
  end

  tdmoa_tx #(.NSLOT(NSLOT)) u_tx (
    .clk(clk), .rst_n(rst_s), .step(step), .hit(hit[0]), .slot(slot[0]),
    .bitn(bitn[0]), .tx_byte(tx_byte), .slot_en(tx_slot_en),
    .tx_data(tx_data), .tx_oe(tx_oe), .tx_ts(tx_ts)
  );

  tdmoa_rx #(.NSLOT(NSLOT)) u_rx (
    .clk(clk), .rst_n(rst_s), .step(step), .sync_evt(sync_evt), .hit(hit[1]),
    .slot(slot[1]), .bitn(bitn[1]), .rx_data(rx_data),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ts(rx_ts)
  );
endmodule

// File: rtl/tdmoa_chk.sv
module tdmoa_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_ck,
  input logic tx_data,
  input logic tx_oe,
  input logic rx_valid,
  input logic aligned
);
  // R7 / R2: nothing is driven or delivered before lock
  p_quiet_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (!tx_oe && !rx_valid));

  // R8: byte strobe lasts one clk cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: transmit outputs only move after a highway clock transition
  p_hold_between_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hw_ck) |=> ($stable(tx_data) && $stable(tx_oe)));

  // R10: lock is never lost, even across a resync
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);
endmodule

bind tdmoa_top tdmoa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_ck(hw_ck), .tx_data(tx_data),
  .tx_oe(tx_oe), .rx_valid(rx_valid), .aligned(aligned)
);

// File: tb/tdmoa_top_tb.sv
`timescale 1ns/1ps
module tdmoa_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_2x, hw_ck, hw_fs;
  logic [6:0]  t_byte, r_byte;
  logic [2:0]  t_bit, r_bit;
  logic        t_half, t_quar, r_half, r_quar;
  logic [7:0]  tx_byte;
  logic [31:0] slot_en;
  logic        tx_data, tx_oe, rx_data, rx_valid, aligned;
  logic [4:0]  tx_ts, rx_ts;
  logic [7:0]  rx_byte;

  always #2 clk = ~clk;

  tdmoa_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_2x(mode_2x), .hw_ck(hw_ck), .hw_fs(hw_fs),
    .tx_byte_off(t_byte), .tx_bit_off(t_bit), .tx_half(t_half), .tx_quar(t_quar),
    .rx_byte_off(r_byte), .rx_bit_off(r_bit), .rx_half(r_half), .rx_quar(r_quar),
    .tx_byte(tx_byte), .tx_slot_en(slot_en), .tx_data(tx_data), .tx_oe(tx_oe),
    .tx_ts(tx_ts), .rx_data(rx_data), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ts(rx_ts), .aligned(aligned)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, seed = 0, e = 0;
  bit locked = 0, tseen = 0, rprimed = 0, done = 0;
  string cur_tag = "R3";

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp=<100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d (edge %0d)", req, act, exp, e);
    end
  endtask

  function automatic logic [7:0] pat(int s);
    return 8'((s * 29 + seed) & 255);
  endfunction

  function automatic int offs(bit m2, int by, int bt, bit h, bit q);
    if (m2) return (by % 32) * 32 + bt * 4 + h * 2 + q;
    return (by % 32) * 16 + bt * 2 + h;
  endfunction

  // One highway clock transition, then check after the output register
  task automatic step_edge(bit fs, bit do_chk);
    int len, bl, ne, tpos, rpos, tbi, rbi;
    bit syn;
    len = mode_2x ? 1024 : 512;
    bl  = mode_2x ? 4 : 2;
    syn = fs && (hw_ck == 1'b1);
    ne  = e;
    if (syn) begin ne = 0; locked = 1; tseen = 0; rprimed = 0; end
    else if (locked) ne = (e + 1) % len;
    tpos = (ne - offs(mode_2x, t_byte, t_bit, t_half, t_quar) + len) % len;
    rpos = (ne - offs(mode_2x, r_byte, r_bit, r_half, r_quar) + len) % len;
    tbi = tpos / bl;
    rbi = rpos / bl;
    @(negedge clk);
    hw_fs   = fs;
    hw_ck   = ~hw_ck;
    rx_data = pat(rbi / 8)[rbi % 8];
    @(negedge clk);
    e = ne;
    hw_fs = 1'b0;
    chk("R10 aligned", int'(aligned), int'(locked));
    if (locked && do_chk) begin
      if (tpos % bl == 0 && tbi % 8 == 0) tseen = 1;
      if (tseen) begin
        chk({cur_tag, " tx_ts"}, int'(tx_ts), tbi / 8);
        chk("R7 tx_oe", int'(tx_oe), int'(slot_en[tbi / 8]));
        chk("R6 tx_data", int'(tx_data), int'(tx_byte[tbi % 8]));
      end
      if (rpos % bl == bl / 2 && rbi % 8 == 7 && rprimed) begin
        chk("R8 rx_valid", int'(rx_valid), 1);
        chk({cur_tag, " R8 rx_byte"}, int'(rx_byte), int'(pat(rbi / 8)));
        chk({cur_tag, " R8 rx_ts"}, int'(rx_ts), rbi / 8);
      end else begin
        chk("R8 rx_valid idle", int'(rx_valid), 0);
      end
      if (rpos % bl == bl / 2 && rbi % 8 == 0) rprimed = 1;
    end
    @(negedge clk);
  endtask

  task automatic do_sync();
    if (hw_ck == 1'b0) step_edge(1'b0, 1'b0);
    step_edge(1'b1, 1'b1);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step_edge(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 aligned", int'(aligned), 0);
    chk("R1 tx_oe", int'(tx_oe), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 tx_data", int'(tx_data), 0);
  endtask

  task automatic t_rise_sync();
    step_edge(1'b1, 1'b1);
    chk("R2 rise ignored", int'(aligned), 0);
    chk("R2 no oe", int'(tx_oe), 0);
    step_edge(1'b0, 1'b1);
    chk("R2 fall without fs", int'(aligned), 0);
  endtask

  task automatic cfg(bit m2, int tb, int tbt, bit th, bit tq, int rb, int rbt,
                     bit rh, bit rq, logic [7:0] txb, logic [31:0] en, int sd);
    @(negedge clk);
    mode_2x = m2; t_byte = 7'(tb); t_bit = 3'(tbt); t_half = th; t_quar = tq;
    r_byte = 7'(rb); r_bit = 3'(rbt); r_half = rh; r_quar = rq;
    tx_byte = txb; slot_en = en; seed = sd;
  endtask

  task automatic t_m0_basic();
    cfg(0, 0, 1, 1, 0, 0, 2, 0, 0, 8'hB4, 32'hA5F0_0F3C, 17);
    cur_tag = "R3"; do_sync(); run(520);
    cur_tag = "R9"; run(200);
  endtask

  task automatic t_m0_range();
    cfg(0, 7'b1000011, 5, 0, 1, 31, 7, 1, 1, 8'h6D, 32'h0F0F_F0F0, 91);
    cur_tag = "R5"; do_sync(); run(600);
  endtask

  task automatic t_m1_basic();
    cfg(1, 0, 0, 1, 1, 0, 1, 1, 0, 8'h93, 32'h8001_7E42, 55);
    cur_tag = "R4"; do_sync(); run(1040);
    cur_tag = "R9"; run(300);
  endtask

  task automatic t_m1_range();
    cfg(1, 69, 3, 0, 0, 31, 7, 1, 1, 8'h2E, 32'hFFFF_0001, 203);
    cur_tag = "R5"; do_sync(); run(1100);
  endtask

  task automatic t_resync();
    cfg(0, 3, 2, 1, 0, 10, 4, 0, 0, 8'hC1, 32'h5555_AAAA, 140);
    cur_tag = "R10"; do_sync(); run(151);
    do_sync(); run(400);
  endtask

  initial begin
    rst_n = 1'b0; hw_ck = 1'b0; hw_fs = 1'b0; rx_data = 1'b0;
    mode_2x = 1'b0; t_byte = '0; t_bit = '0; t_half = 1'b0; t_quar = 1'b0;
    r_byte = '0; r_bit = '0; r_half = 1'b0; r_quar = 1'b0;
    tx_byte = '0; slot_en = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_rise_sync();
    t_m0_basic();
    t_m0_range();
    t_m1_basic();
    t_m1_range();
    t_resync();
    finish_run();
  end
endmodule